// File: doc/BRIEF.md
# 8-bit Integer ALU with Deferred Flag Capture

This block is the integer side of a small calculator datapath. It holds an eight-entry file of 8-bit registers, where entry 0 always reads as zero. It executes one three-operand instruction per cycle whenever `instr_valid` is high. Each instruction reads two source registers, or one source register and an 8-bit constant. It writes one destination register. Alongside the result it works out a set of comparison flags from the two operands and the result.

The flags go into a flag register only when the instruction's save bit is set. Two status bits from a neighbouring floating-point unit are captured with them. Conditional branches are evaluated against the flag register, never against the flags of the current instruction. The upper four registers also have a second write port, through which the floating-point side deposits converted values. The interfaces are plain control pins with no back-pressure: an instruction presented with `instr_valid` high is always consumed on that clock edge.

The instruction slice is `IW = 6 + 3*3 + DATA_W + 1` bits, 24 by default. From the most significant end the fields are: opcode [23:18], destination [17:15], source 1 [14:12], source 2 [11:9], immediate [8:1] and save bit [0].

Top module: `ialu_deferred_flags`

## Requirements
- R1: Register 0 reads as zero at all times, and writes addressed to it are discarded.
- R2: For RRR instructions the destination receives the following, modulo 256: for opcode 000001, s1+s2; for 000010, s1+s2+1; for 000011, s1-s2; for 000100, s1-s2-1.
- R3: For 000101, 000110 and 000111 the destination receives s1 OR s2, s1 AND s2 and s1 XOR s2. For 001000 it receives NOT s1. For 001001 it receives s1 shifted right by one with a zero fill, and for 001010 it receives s1 shifted left by one.
- R4: In RRI form the immediate field replaces s2. Opcode 001011 writes s1+imm and 001100 writes s1 AND imm, and the flag comparison uses imm as its second operand.
- R5: Opcode 000000, and any other opcode outside 000001..001100, leaves every register unchanged.
- R6: The flag vector `flags_q` holds, from bit 8 down to bit 0: EQ (op1==op2), N (result bit 7), C, LO (unsigned op1<op2), HI (unsigned op1>op2), LT (signed op1<op2), GT (signed op1>op2), FZ and FN.
- R7: C is the carry out of op1+op2(+1) for addition. For subtraction it is the carry out of op1+~op2+1 for 000011 and of op1+~op2 for 000100, so 1 means that no borrow occurred. For a left shift it is the bit shifted out of bit 7, and for a right shift the bit shifted out of bit 0. It is 0 for every other opcode.
- R8: The flag register loads on a clock edge only when `instr_valid` is high and the save bit is 1. Otherwise it holds its value, and the destination is written in either case.
- R9: FZ and FN capture `fpu_zero` and `fpu_neg` on the same edge as the ALU flags.
- R10: `ext_we` writes `ext_data` into register 4+`ext_addr`. When the ALU writes the same register on the same edge, the ALU value wins.
- R11: `branch_take` is combinational from the registered flags and is high only when `instr_valid` is high. It follows the opcode as listed here:

  | Opcode | Condition |
  |---|---|
  | 001101 | EQ |
  | 001110 | !EQ |
  | 001111 | N |
  | 010000 | !N |
  | 010001 | C |
  | 010010 | !C |
  | 010011 | LO |
  | 010100 | LO\|EQ |
  | 010101 | HI\|EQ |
  | 010110 | HI |
  | 010111 | LT |
  | 011000 | LT\|EQ |
  | 011001 | GT\|EQ |
  | 011010 | GT |
  | 011011 | FZ |
  | 011100 | !FZ |
  | 011101 | FN |
  | 011110 | !FN |
  | 011111 | always |

  Every other opcode gives 0.
- R12: After reset all registers and the flag register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | IW | Instruction slice |
| fpu_zero | input | 1 | Floating-point result is zero |
| fpu_neg | input | 1 | Floating-point result is negative |
| ext_we | input | 1 | Write strobe for the upper registers |
| ext_addr | input | 2 | Upper register select (0 means register 4) |
| ext_data | input | DATA_W | Data for the upper register write |
| dbg_addr | input | 3 | Register read address |
| dbg_data | output | DATA_W | Contents of register dbg_addr |
| flags_q | output | 9 | Registered flags |
| branch_take | output | 1 | Branch condition met |

## Verification
The bench uses the default parameters: an 8-bit datapath, eight registers and four externally writable registers starting at index 4. At this width, operand pairs such as 200 and 100 can be chosen so that the unsigned and signed orderings disagree. The same pairs make addition overflow and subtraction borrow. This means the LO/HI and LT/GT flags and the carry definition are each separated by a single instruction. With four upper registers, both the plain external write and a same-cycle collision with an ALU write can be driven at register 5.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
  localparam int DATA_W = 8;
  localparam int OP_W   = 6;
  localparam int RA_W   = 3;
  localparam int IW     = OP_W + 3 * RA_W + DATA_W + 1;
  localparam int SAVE_BIT = 0;
  localparam int IMM_LSB  = 1;
  localparam int RS2_LSB  = IMM_LSB + DATA_W;
  localparam int RS1_LSB  = RS2_LSB + RA_W;
  localparam int RD_LSB   = RS1_LSB + RA_W;
  localparam int OP_LSB   = RD_LSB + RA_W;

  localparam logic [OP_W-1:0] OP_NOP  = 6'b000000;
  localparam logic [OP_W-1:0] OP_ADD  = 6'b000001;
  localparam logic [OP_W-1:0] OP_ADC  = 6'b000010;
  localparam logic [OP_W-1:0] OP_SUB  = 6'b000011;
  localparam logic [OP_W-1:0] OP_SBC  = 6'b000100;
  localparam logic [OP_W-1:0] OP_OR   = 6'b000101;
  localparam logic [OP_W-1:0] OP_AND  = 6'b000110;
  localparam logic [OP_W-1:0] OP_XOR  = 6'b000111;
  localparam logic [OP_W-1:0] OP_NOT  = 6'b001000;
  localparam logic [OP_W-1:0] OP_SHR  = 6'b001001;
  localparam logic [OP_W-1:0] OP_SHL  = 6'b001010;
  localparam logic [OP_W-1:0] OP_ADDI = 6'b001011;
  localparam logic [OP_W-1:0] OP_ANDI = 6'b001100;
  localparam logic [OP_W-1:0] OP_JMP  = 6'b011111;

  typedef struct packed {
    logic eq;
    logic n;
    logic c;
    logic lo;
    logic hi;
    logic lt;
    logic gt;
    logic fz;
    logic fn;
  } flags_t;
endpackage

// File: rtl/ialu_regfile.sv
module ialu_regfile #(
  parameter int DATA_W   = 8,
  parameter int NREG     = 8,
  parameter int EXT_BASE = 4,
  parameter int EXT_CNT  = 4,
  localparam int AW  = $clog2(NREG),
  localparam int EAW = $clog2(EXT_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_we,
  input  logic [AW-1:0]     alu_wa,
  input  logic [DATA_W-1:0] alu_wd,
  input  logic              ext_we,
  input  logic [EAW-1:0]    ext_wa,
  input  logic [DATA_W-1:0] ext_wd,
  input  logic [AW-1:0]     ra1,
  input  logic [AW-1:0]     ra2,
  input  logic [AW-1:0]     ra3,
  output logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] rd2,
  output logic [DATA_W-1:0] rd3
);
  logic [NREG-1:0][DATA_W-1:0] regs;

  assign regs[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic ext_hit;
    if (i >= EXT_BASE && i < EXT_BASE + EXT_CNT) begin : g_ext
      assign ext_hit = ext_we && ((int'(ext_wa) + EXT_BASE) == i);
    end else begin : g_int
      assign ext_hit = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                             q <= '0;
      else if (alu_we && alu_wa == AW'(i))    q <= alu_wd;
      else if (ext_hit)                       q <= ext_wd;
    end
    assign regs[i] = q;

    p_alu_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_we && alu_wa == AW'(i)) |=> (q == $past(alu_wd)));
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
  assign rd3 = regs[ra3];
endmodule

// File: rtl/ialu_exec.sv
module ialu_exec
  import ialu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] s1,
  input  logic [DATA_W-1:0] s2,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] res,
  output logic              we,
  output logic              f_eq,
  output logic              f_n,
  output logic              f_c,
  output logic              f_lo,
  output logic              f_hi,
  output logic              f_lt,
  output logic              f_gt
);
  logic [DATA_W-1:0] b, badd;
  logic              cin, rri;
  logic [DATA_W:0]   sum;

  always_comb begin
    rri = (op == OP_ADDI) || (op == OP_ANDI);
    b   = rri ? imm : s2;
    case (op)
      OP_ADC:  begin badd = b;  cin = 1'b1; end
      OP_SUB:  begin badd = ~b; cin = 1'b1; end
      OP_SBC:  begin badd = ~b; cin = 1'b0; end
      default: begin badd = b;  cin = 1'b0; end
    endcase
    sum = {1'b0, s1} + {1'b0, badd} + {{DATA_W{1'b0}}, cin};

    res = '0;
    f_c = 1'b0;
    we  = 1'b1;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_ADDI: begin
        res = sum[DATA_W-1:0];
        f_c = sum[DATA_W];
      end
      OP_OR:   res = s1 | b;
      OP_AND, OP_ANDI: res = s1 & b;
      OP_XOR:  res = s1 ^ b;
      OP_NOT:  res = ~s1;
      OP_SHR:  begin res = {1'b0, s1[DATA_W-1:1]}; f_c = s1[0]; end
      OP_SHL:  begin res = {s1[DATA_W-2:0], 1'b0}; f_c = s1[DATA_W-1]; end
      default: we = 1'b0;
    endcase

    f_eq = (s1 == b);
    f_n  = res[DATA_W-1];
    f_lo = (s1 < b);
    f_hi = (s1 > b);
    f_lt = ($signed(s1) < $signed(b));
    f_gt = ($signed(s1) > $signed(b));
  end

  p_eq_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    f_eq |-> !(f_lo || f_hi || f_lt || f_gt));

  p_sub_noborrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SUB) |-> (f_c == (s1 >= s2)));

  p_nop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NOP) |-> !we);
endmodule

// File: rtl/ialu_flag_reg.sv
module ialu_flag_reg
  import ialu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q.fz == $past(d.fz) && q.fn == $past(d.fn)));
endmodule

// File: rtl/ialu_branch.sv
module ialu_branch
  import ialu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic [OP_W-1:0] op,
  input  flags_t          f,
  output logic            take
);
  logic cond;

  always_comb begin
    case (op)
      6'b001101: cond = f.eq;
      6'b001110: cond = !f.eq;
      6'b001111: cond = f.n;
      6'b010000: cond = !f.n;
      6'b010001: cond = f.c;
      6'b010010: cond = !f.c;
      6'b010011: cond = f.lo;
      6'b010100: cond = f.lo || f.eq;
      6'b010101: cond = f.hi || f.eq;
      6'b010110: cond = f.hi;
      6'b010111: cond = f.lt;
      6'b011000: cond = f.lt || f.eq;
      6'b011001: cond = f.gt || f.eq;
      6'b011010: cond = f.gt;
      6'b011011: cond = f.fz;
      6'b011100: cond = !f.fz;
      6'b011101: cond = f.fn;
      6'b011110: cond = !f.fn;
      6'b011111: cond = 1'b1;
      default:   cond = 1'b0;
    endcase
    take = valid && cond;
  end

  p_jmp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op == OP_JMP) |-> take);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !take);
endmodule

// File: rtl/ialu_deferred_flags.sv
module ialu_deferred_flags
  import ialu_pkg::*;
#(
  parameter int DW       = ialu_pkg::DATA_W,
  parameter int NREG     = 8,
  parameter int EXT_BASE = 4,
  parameter int EXT_CNT  = 4,
  localparam int AW  = $clog2(NREG),
  localparam int EAW = $clog2(EXT_CNT),
  localparam int FW  = $bits(flags_t)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           instr_valid,
  input  logic [IW-1:0]  instr,
  input  logic           fpu_zero,
  input  logic           fpu_neg,
  input  logic           ext_we,
  input  logic [EAW-1:0] ext_addr,
  input  logic [DW-1:0]  ext_data,
  input  logic [AW-1:0]  dbg_addr,
  output logic [DW-1:0]  dbg_data,
  output logic [FW-1:0]  flags_q,
  output logic           branch_take
);
  logic [OP_W-1:0] op;
  logic [AW-1:0]   rd_a, rs1_a, rs2_a;
  logic [DW-1:0]   imm, s1, s2, res;
  logic            exe_we;
  flags_t          f_nx, f_q;

  assign op    = instr[OP_LSB +: OP_W];
  assign rd_a  = instr[RD_LSB +: AW];
  assign rs1_a = instr[RS1_LSB +: AW];
  assign rs2_a = instr[RS2_LSB +: AW];
  assign imm   = instr[IMM_LSB +: DW];

  ialu_regfile #(
    .DATA_W(DW), .NREG(NREG), .EXT_BASE(EXT_BASE), .EXT_CNT(EXT_CNT)
  ) u_rf (
    .clk(clk), .rst_n(rst_n),
    .alu_we(instr_valid && exe_we), .alu_wa(rd_a), .alu_wd(res),
    .ext_we(ext_we), .ext_wa(ext_addr), .ext_wd(ext_data),
    .ra1(rs1_a), .ra2(rs2_a), .ra3(dbg_addr),
    .rd1(s1), .rd2(s2), .rd3(dbg_data)
  );

  ialu_exec #(.DATA_W(DW)) u_exec (
    .clk(clk), .rst_n(rst_n),
    .op(op), .s1(s1), .s2(s2), .imm(imm),
    .res(res), .we(exe_we),
    .f_eq(f_nx.eq), .f_n(f_nx.n), .f_c(f_nx.c),
    .f_lo(f_nx.lo), .f_hi(f_nx.hi), .f_lt(f_nx.lt), .f_gt(f_nx.gt)
  );

  assign f_nx.fz = fpu_zero;
  assign f_nx.fn = fpu_neg;

  ialu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n),
    .load(instr_valid && instr[SAVE_BIT]),
    .d(f_nx), .q(f_q)
  );

  ialu_branch u_br (
    .clk(clk), .rst_n(rst_n),
    .valid(instr_valid), .op(op), .f(f_q), .take(branch_take)
  );

  assign flags_q = f_q;
endmodule

// File: tb/ialu_deferred_flags_bench.sv
module ialu_deferred_flags_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [23:0] instr = '0;
  logic        fpu_zero = 1'b0, fpu_neg = 1'b0;
  logic        ext_we = 1'b0;
  logic [1:0]  ext_addr = '0;
  logic [7:0]  ext_data = '0;
  logic [2:0]  dbg_addr = '0;
  logic [7:0]  dbg_data;
  logic [8:0]  flags_q;
  logic        branch_take;
  int          n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  ialu_deferred_flags u_ialu_deferred_flags (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .fpu_zero(fpu_zero), .fpu_neg(fpu_neg), .ext_we(ext_we),
    .ext_addr(ext_addr), .ext_data(ext_data), .dbg_addr(dbg_addr),
    .dbg_data(dbg_data), .flags_q(flags_q), .branch_take(branch_take)
  );

  function automatic logic [23:0] enc(input logic [5:0] op, input logic [2:0] d,
      input logic [2:0] a, input logic [2:0] b, input logic [7:0] imm, input logic sv);
    return {op, d, a, b, imm, sv};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [23:0] w);
    @(negedge clk);
    instr = w; instr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0; ext_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    dbg_addr = a; #1;
    chk(req, {24'd0, dbg_data}, {24'd0, exp});
  endtask

  task automatic br_chk(input string req, input logic [5:0] op, input logic v, input logic exp);
    instr = enc(op, 3'd0, 3'd0, 3'd0, 8'd0, 1'b0); instr_valid = v; #1;
    chk(req, {31'd0, branch_take}, {31'd0, exp});
    instr_valid = 1'b0; #1;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) rd_chk("R12 reg", 3'(i), 8'd0);
    chk("R12 flags", {23'd0, flags_q}, 32'd0);
  endtask

  task automatic t_r0;
    issue(enc(6'b001011, 3'd0, 3'd0, 3'd0, 8'd5, 1'b0));
    rd_chk("R1 r0 write dropped", 3'd0, 8'd0);
  endtask

  task automatic t_load;
    issue(enc(6'b001011, 3'd1, 3'd0, 3'd0, 8'd200, 1'b0));
    issue(enc(6'b001011, 3'd2, 3'd0, 3'd0, 8'd100, 1'b0));
    rd_chk("R4 addi r1", 3'd1, 8'd200);
    rd_chk("R4 addi r2", 3'd2, 8'd100);
  endtask

  task automatic t_addfam;
    fpu_zero = 1'b1; fpu_neg = 1'b0;
    issue(enc(6'b000001, 3'd3, 3'd1, 3'd2, 8'd0, 1'b1));
    rd_chk("R2 add", 3'd3, 8'd44);
    chk("R6 R7 R9 add flags", {23'd0, flags_q}, {23'd0, 9'b001011010});
    issue(enc(6'b000010, 3'd3, 3'd1, 3'd2, 8'd0, 1'b0));
    rd_chk("R2 adc", 3'd3, 8'd45);
    fpu_zero = 1'b0; fpu_neg = 1'b1;
    issue(enc(6'b000011, 3'd4, 3'd2, 3'd1, 8'd0, 1'b1));
    rd_chk("R2 sub", 3'd4, 8'd156);
    chk("R6 R7 R9 sub flags", {23'd0, flags_q}, {23'd0, 9'b010100101});
    fpu_neg = 1'b0;
    issue(enc(6'b000100, 3'd5, 3'd1, 3'd2, 8'd0, 1'b1));
    rd_chk("R2 sbc", 3'd5, 8'd99);
    chk("R7 sbc flags", {23'd0, flags_q}, {23'd0, 9'b001011000});
  endtask

  task automatic t_logic;
    issue(enc(6'b000101, 3'd6, 3'd1, 3'd2, 8'd0, 1'b0)); rd_chk("R3 or",  3'd6, 8'hEC);
    issue(enc(6'b000110, 3'd6, 3'd1, 3'd2, 8'd0, 1'b0)); rd_chk("R3 and", 3'd6, 8'h40);
    issue(enc(6'b000111, 3'd6, 3'd1, 3'd2, 8'd0, 1'b0)); rd_chk("R3 xor", 3'd6, 8'hAC);
    issue(enc(6'b001000, 3'd6, 3'd1, 3'd2, 8'd0, 1'b0)); rd_chk("R3 not", 3'd6, 8'h37);
    issue(enc(6'b001001, 3'd6, 3'd1, 3'd2, 8'd0, 1'b1)); rd_chk("R3 shr", 3'd6, 8'd100);
    chk("R7 shr carry", {31'd0, flags_q[6]}, 32'd0);
    issue(enc(6'b001010, 3'd6, 3'd1, 3'd1, 8'd0, 1'b1)); rd_chk("R3 shl", 3'd6, 8'h90);
    chk("R7 shl flags", {23'd0, flags_q}, {23'd0, 9'b111000000});
  endtask

  task automatic t_rri;
    issue(enc(6'b001100, 3'd6, 3'd1, 3'd2, 8'h0F, 1'b0)); rd_chk("R4 andi", 3'd6, 8'h08);
    issue(enc(6'b001110, 3'd0, 3'd0, 3'd0, 8'd0, 1'b1));
    issue(enc(6'b001011, 3'd7, 3'd1, 3'd2, 8'd200, 1'b1));
    rd_chk("R4 addi wrap", 3'd7, 8'd144);
    chk("R4 R6 imm compare flags", {23'd0, flags_q}, {23'd0, 9'b111000000});
  endtask

  task automatic t_nosave;
    fpu_zero = 1'b1; fpu_neg = 1'b1;
    issue(enc(6'b000011, 3'd6, 3'd2, 3'd1, 8'd0, 1'b0));
    chk("R8 flags held", {23'd0, flags_q}, {23'd0, 9'b111000000});
    rd_chk("R8 dest written", 3'd6, 8'd156);
    fpu_zero = 1'b0; fpu_neg = 1'b0;
  endtask

  task automatic t_branch;
    @(negedge clk);
    br_chk("R11 eq",    6'b001101, 1'b1, 1'b1);
    br_chk("R11 ne",    6'b001110, 1'b1, 1'b0);
    br_chk("R11 mi",    6'b001111, 1'b1, 1'b1);
    br_chk("R11 cs",    6'b010001, 1'b1, 1'b1);
    br_chk("R11 hi",    6'b010110, 1'b1, 1'b0);
    br_chk("R11 lo|eq", 6'b010100, 1'b1, 1'b1);
    br_chk("R11 gt",    6'b011010, 1'b1, 1'b0);
    br_chk("R11 fz",    6'b011011, 1'b1, 1'b0);
    br_chk("R11 !fz",   6'b011100, 1'b1, 1'b1);
    br_chk("R11 jmp",   6'b011111, 1'b1, 1'b1);
    br_chk("R11 alu op", 6'b000001, 1'b1, 1'b0);
    br_chk("R11 idle",  6'b011111, 1'b0, 1'b0);
  endtask

  task automatic t_nop;
    issue(enc(6'b000000, 3'd1, 3'd2, 3'd2, 8'd0, 1'b0));
    rd_chk("R5 nop keeps r1", 3'd1, 8'd200);
    issue(enc(6'b011111, 3'd2, 3'd1, 3'd1, 8'd0, 1'b0));
    rd_chk("R5 branch op keeps r2", 3'd2, 8'd100);
  endtask

  task automatic t_fpu;
    fpu_zero = 1'b1; fpu_neg = 1'b1;
    issue(enc(6'b000000, 3'd0, 3'd1, 3'd1, 8'd0, 1'b1));
    chk("R9 fpu bits", {23'd0, flags_q}, {23'd0, 9'b100000011});
    fpu_zero = 1'b0; fpu_neg = 1'b0;
  endtask

  task automatic t_ext;
    @(negedge clk);
    ext_we = 1'b1; ext_addr = 2'd0; ext_data = 8'h5A;
    @(posedge clk); @(negedge clk); ext_we = 1'b0;
    rd_chk("R10 ext r4", 3'd4, 8'h5A);
    ext_we = 1'b1; ext_addr = 2'd1; ext_data = 8'h33;
    issue(enc(6'b001011, 3'd5, 3'd0, 3'd0, 8'h11, 1'b0));
    rd_chk("R10 alu wins", 3'd5, 8'h11);
    @(negedge clk);
    ext_we = 1'b1; ext_addr = 2'd1; ext_data = 8'h33;
    @(posedge clk); @(negedge clk); ext_we = 1'b0;
    rd_chk("R10 ext r5", 3'd5, 8'h33);
    rd_chk("R1 r0 still zero", 3'd0, 8'd0);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset;
    t_r0;
    t_load;
    t_addfam;
    t_logic;
    t_rri;
    t_nosave;
    t_branch;
    t_nop;
    t_fpu;
    t_ext;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule